// File: doc/BRIEF.md
# Sync-Referenced Clamp Pulse Generator

This block sits in the pixel clock domain of a video front end. It produces the clamp timing for the input channels and clean, polarity-adjusted copies of the line and frame sync. The raw horizontal sync, vertical sync, coast and external clamp pins are each brought into the clock domain through a two-stage synchronizer. The leading edge of horizontal sync is then found according to a programmed input polarity. While the coast input is at its programmed active level, leading edges are discarded. This lets the line timing coast through equalisation or missing pulses.

The clamp output has two sources. In internal mode, each accepted leading edge starts a pixel counter. The clamp pulse begins a programmed number of pixels after the edge and lasts a programmed number of pixels. In external mode, the clamp output follows the synchronized external clamp pin, with a selectable active level. All configuration arrives as static register bits. The controlling register file is expected to reset them to: input sync polarity high, coast polarity high, internal clamp source, external clamp polarity high, sync output positive and frame sync inverted.

Top module: `sync_clamp_gen`

## Requirements
- R1: With `cfgHsInPol`=1, a low-to-high transition of `hsyncIn` is the leading edge. A high-to-low transition starts nothing.
- R2: With `cfgHsInPol`=0, a high-to-low transition of `hsyncIn` is the leading edge. A low-to-high transition starts nothing.
- R3: With `cfgClampSrc`=0, suppose an accepted leading edge has its new `hsyncIn` level first sampled at clock edge n. Then `clampOut` is high (active high) after edges n+3+`cfgPlace` through n+2+`cfgPlace`+`cfgDur`, and low otherwise. Placement and duration are 8-bit unsigned pixel counts.
- R4: With `cfgClampSrc`=0 and `cfgDur`=0, `clampOut` never goes high.
- R5: A leading edge accepted before the running clamp pulse has finished restarts placement counting from zero. The earlier pending pulse is dropped.
- R6: `coastIn` is active when it equals `cfgCoastPol`. A leading edge whose new level is sampled while coast is active is ignored and starts no clamp timing.
- R7: With `cfgClampSrc`=1, `clampOut` after edge n is 1 exactly when `clampExtIn` sampled at edge n-2 equals `cfgClampPol`. A value of 1 means the external pin is active high.
- R8: `hsyncOut` after edge n is 1 exactly when the `hsyncIn` level sampled at edge n-2 is its active level (equal to `cfgHsInPol`) and `cfgHsOutPol`=1, or when it is inactive and `cfgHsOutPol`=0.
- R9: `vsyncOut` after edge n equals `vsyncIn` sampled at edge n-2, XORed with `cfgVsInvert`.
- R10: While `rstN` is low, all three outputs are 0, and no clamp timing is pending after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hsyncIn | input | 1 | Raw horizontal sync |
| vsyncIn | input | 1 | Raw vertical sync |
| coastIn | input | 1 | Raw coast request |
| clampExtIn | input | 1 | Raw external clamp |
| cfgHsInPol | input | 1 | Horizontal sync input active level (1 = high) |
| cfgCoastPol | input | 1 | Coast active level (1 = high) |
| cfgClampSrc | input | 1 | Clamp source: 0 internal counter, 1 external pin |
| cfgClampPol | input | 1 | External clamp active level (1 = high) |
| cfgHsOutPol | input | 1 | Horizontal sync output: 1 positive pulse, 0 negative pulse |
| cfgVsInvert | input | 1 | Invert vertical sync output when 1 |
| cfgPlace | input | 8 | Pixels from leading edge to clamp start |
| cfgDur | input | 8 | Clamp length in pixels |
| hsyncOut | output | 1 | Polarity-adjusted horizontal sync |
| vsyncOut | output | 1 | Polarity-adjusted vertical sync |
| clampOut | output | 1 | Active-high clamp pulse |

## Verification
Sync pulses of both polarities are driven under each input-polarity setting. This separates leading-edge detection from trailing-edge detection, and the exact cycle of each clamp rise shows the three-stage latency. Pulse trains spaced closer than placement plus duration show that a restart drops the pending pulse rather than letting it complete. Pulses sent while coast is held at either active level show that coast gating follows its polarity bit. Random rounds mix pulse widths, gaps, coast toggling, external clamp activity and configuration, and compare every output in every cycle against a reference model.

// File: rtl/clampgen_pkg.sv
package clampgen_pkg;

  // index of each raw input inside the synchronizer bank
  localparam int SigHs    = 0;
  localparam int SigVs    = 1;
  localparam int SigCoast = 2;
  localparam int SigClamp = 3;
  localparam int NumSig   = 4;

  // control -> datapath strobes
  typedef struct packed {
    logic restart;   // accepted leading edge: zero the pixel counter
    logic advance;   // count one pixel
    logic clampOn;   // internal clamp window is open this cycle
  } clampStb_t;

  // datapath -> control status
  typedef struct packed {
    logic lastCount; // counter has reached the end of the window
    logic inWindow;  // counter lies inside [place, place+dur)
  } cntStat_t;

endpackage

// File: rtl/clampgen_dp.sv
module clampgen_dp
  import clampgen_pkg::*;
#(
  parameter int PosW       = 8,
  parameter int SyncStages = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NumSig-1:0] rawIn,
  input  logic            cfgHsInPol,
  input  logic            cfgClampSrc,
  input  logic            cfgClampPol,
  input  logic            cfgHsOutPol,
  input  logic            cfgVsInvert,
  input  logic [PosW-1:0] cfgPlace,
  input  logic [PosW-1:0] cfgDur,
  input  clampStb_t       stb,
  output cntStat_t        stat,
  output logic            hsSync,
  output logic            coastSync,
  output logic            hsyncOut,
  output logic            vsyncOut,
  output logic            clampOut
);

  localparam int CntW = PosW + 1;

  logic [NumSig-1:0] syncd;

  // one synchronizer chain per raw input
  for (genvar i = 0; i < NumSig; i++) begin : g_sync
    logic [SyncStages-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[SyncStages-2:0], rawIn[i]};
    end
    assign syncd[i] = chain[SyncStages-1];
  end

  assign hsSync    = syncd[SigHs];
  assign coastSync = syncd[SigCoast];

  // pixel counter measured from the accepted leading edge
  logic [CntW-1:0] pixCnt;
  logic [CntW-1:0] winStart;
  logic [CntW-1:0] winEnd;

  assign winStart = {1'b0, cfgPlace};
  assign winEnd   = {1'b0, cfgPlace} + {1'b0, cfgDur};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            pixCnt <= '0;
    else if (stb.restart) pixCnt <= '0;
    else if (stb.advance) pixCnt <= pixCnt + CntW'(1);
  end

  assign stat.lastCount = (pixCnt + CntW'(1)) >= winEnd;
  assign stat.inWindow  = (pixCnt >= winStart) && (pixCnt < winEnd);

  // registered outputs
  logic hsActive;
  logic extActive;

  assign hsActive  = (syncd[SigHs] == cfgHsInPol);
  assign extActive = (syncd[SigClamp] == cfgClampPol);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsyncOut <= 1'b0;
      vsyncOut <= 1'b0;
      clampOut <= 1'b0;
    end else begin
      hsyncOut <= (hsActive == cfgHsOutPol);
      vsyncOut <= syncd[SigVs] ^ cfgVsInvert;
      clampOut <= cfgClampSrc ? extActive : stb.clampOn;
    end
  end

endmodule

// File: rtl/clampgen_ctrl.sv
module clampgen_ctrl
  import clampgen_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      hsSync,
  input  logic      coastSync,
  input  logic      cfgHsInPol,
  input  logic      cfgCoastPol,
  input  cntStat_t  stat,
  output clampStb_t stb
);

  logic hsPrev;
  logic running;
  logic leadEdge;
  logic coastOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hsPrev <= 1'b0;
    else       hsPrev <= hsSync;
  end

  // the leading edge direction follows the input polarity bit
  assign leadEdge = cfgHsInPol ? (hsSync & ~hsPrev) : (~hsSync & hsPrev);
  assign coastOn  = (coastSync == cfgCoastPol);

  assign stb.restart = leadEdge & ~coastOn;
  assign stb.advance = running & ~stb.restart & ~stat.lastCount;
  assign stb.clampOn = running & stat.inWindow;

  // a new accepted edge always wins over a pulse still in progress
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        running <= 1'b0;
    else if (stb.restart)             running <= 1'b1;
    else if (running && stat.lastCount) running <= 1'b0;
  end

endmodule

// File: rtl/sync_clamp_gen.sv
module sync_clamp_gen
  import clampgen_pkg::*;
#(
  parameter int PosW       = 8,
  parameter int SyncStages = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            hsyncIn,
  input  logic            vsyncIn,
  input  logic            coastIn,
  input  logic            clampExtIn,
  input  logic            cfgHsInPol,
  input  logic            cfgCoastPol,
  input  logic            cfgClampSrc,
  input  logic            cfgClampPol,
  input  logic            cfgHsOutPol,
  input  logic            cfgVsInvert,
  input  logic [PosW-1:0] cfgPlace,
  input  logic [PosW-1:0] cfgDur,
  output logic            hsyncOut,
  output logic            vsyncOut,
  output logic            clampOut
);

  logic [NumSig-1:0] rawIn;
  clampStb_t         ctrlStb;
  cntStat_t          cntStat;
  logic              hsSync;
  logic              coastSync;

  always_comb begin
    rawIn           = '0;
    rawIn[SigHs]    = hsyncIn;
    rawIn[SigVs]    = vsyncIn;
    rawIn[SigCoast] = coastIn;
    rawIn[SigClamp] = clampExtIn;
  end

  clampgen_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .hsSync     (hsSync),
    .coastSync  (coastSync),
    .cfgHsInPol (cfgHsInPol),
    .cfgCoastPol(cfgCoastPol),
    .stat       (cntStat),
    .stb        (ctrlStb)
  );

  clampgen_dp #(
    .PosW      (PosW),
    .SyncStages(SyncStages)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .rawIn      (rawIn),
    .cfgHsInPol (cfgHsInPol),
    .cfgClampSrc(cfgClampSrc),
    .cfgClampPol(cfgClampPol),
    .cfgHsOutPol(cfgHsOutPol),
    .cfgVsInvert(cfgVsInvert),
    .cfgPlace   (cfgPlace),
    .cfgDur     (cfgDur),
    .stb        (ctrlStb),
    .stat       (cntStat),
    .hsSync     (hsSync),
    .coastSync  (coastSync),
    .hsyncOut   (hsyncOut),
    .vsyncOut   (vsyncOut),
    .clampOut   (clampOut)
  );

endmodule

// File: rtl/clampgen_chk.sv
module clampgen_chk
  import clampgen_pkg::*;
#(
  parameter int PosW = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            vsyncIn,
  input logic            clampExtIn,
  input logic            cfgHsInPol,
  input logic            cfgCoastPol,
  input logic            cfgClampSrc,
  input logic            cfgClampPol,
  input logic            cfgVsInvert,
  input logic [PosW-1:0] cfgPlace,
  input logic [PosW-1:0] cfgDur,
  input logic            vsyncOut,
  input logic            clampOut,
  input logic            hsSync,
  input logic            coastSync,
  input clampStb_t       stb
);

  // edges seen since reset release, saturating
  logic [1:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  // R1 / R2: a restart only happens when sync has just reached its active level
  p_edge_level_r1: assert property (@(posedge clk) disable iff (!rstN)
    stb.restart |-> (hsSync == cfgHsInPol));
  p_edge_change_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.restart |-> (hsSync != $past(hsSync)));

  // R4: a zero duration never opens the window
  p_zero_dur_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.clampOn |-> (cfgDur != '0));

  // R5: after a restart the counter is at zero, so only a zero placement can open the window
  p_restart_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.restart |=> ((cfgPlace == '0) || !stb.clampOn));

  // R6: no restart while coast is active
  p_coast_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.restart |-> (coastSync != cfgCoastPol));

  // R7: external clamp follows the pin three edges back
  p_ext_clamp_r7: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3) && $past(cfgClampSrc) |->
      (clampOut == ($past(clampExtIn, 3) == $past(cfgClampPol))));

  // R9: frame sync passes with optional inversion
  p_vsync_r9: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3) |-> (vsyncOut == ($past(vsyncIn, 3) ^ $past(cfgVsInvert))));

endmodule

bind sync_clamp_gen clampgen_chk #(.PosW(PosW)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .vsyncIn    (vsyncIn),
  .clampExtIn (clampExtIn),
  .cfgHsInPol (cfgHsInPol),
  .cfgCoastPol(cfgCoastPol),
  .cfgClampSrc(cfgClampSrc),
  .cfgClampPol(cfgClampPol),
  .cfgVsInvert(cfgVsInvert),
  .cfgPlace   (cfgPlace),
  .cfgDur     (cfgDur),
  .vsyncOut   (vsyncOut),
  .clampOut   (clampOut),
  .hsSync     (hsSync),
  .coastSync  (coastSync),
  .stb        (ctrlStb)
);

// File: tb/sync_clamp_gen_tb.sv
`timescale 1ns/1ps
module sync_clamp_gen_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hsyncIn = 1'b0, vsyncIn = 1'b0, coastIn = 1'b0, clampExtIn = 1'b0;
  logic       cfgHsInPol = 1'b1, cfgCoastPol = 1'b1, cfgClampSrc = 1'b0;
  logic       cfgClampPol = 1'b1, cfgHsOutPol = 1'b1, cfgVsInvert = 1'b1;
  logic [7:0] cfgPlace = 8'd4, cfgDur = 8'd6;
  logic       hsyncOut, vsyncOut, clampOut;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  string phaseTag = "R3";

  always #2.5 clk = ~clk;

  sync_clamp_gen u_dut (
    .clk(clk), .rstN(rstN),
    .hsyncIn(hsyncIn), .vsyncIn(vsyncIn), .coastIn(coastIn), .clampExtIn(clampExtIn),
    .cfgHsInPol(cfgHsInPol), .cfgCoastPol(cfgCoastPol), .cfgClampSrc(cfgClampSrc),
    .cfgClampPol(cfgClampPol), .cfgHsOutPol(cfgHsOutPol), .cfgVsInvert(cfgVsInvert),
    .cfgPlace(cfgPlace), .cfgDur(cfgDur),
    .hsyncOut(hsyncOut), .vsyncOut(vsyncOut), .clampOut(clampOut)
  );

  // ---------------- reference model ----------------
  function automatic logic isActive(logic v, logic pol);
    return v == pol;
  endfunction

  function automatic logic inPulse(bit have, int edgeAt, int now, int place, int dur);
    return have && (now >= edgeAt + 3 + place) && (now < edgeAt + 3 + place + dur);
  endfunction

  logic [3:0] hsH, vsH, coH, exH;   // bit k = sample at edge n-1-k
  int  cyc;
  int  lastEdge;
  bit  haveEdge;
  logic expHs = 0, expVs = 0, expClamp = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      hsH = '0; vsH = '0; coH = '0; exH = '0;
      cyc = 0; haveEdge = 0; lastEdge = 0;
      expHs = 0; expVs = 0; expClamp = 0;
    end else begin
      cyc++;
      if (isActive(hsH[2], cfgHsInPol) && !isActive(hsH[3], cfgHsInPol) &&
          !isActive(coH[2], cfgCoastPol)) begin
        haveEdge = 1;
        lastEdge = cyc - 3;
      end
      expHs = (isActive(hsH[1], cfgHsInPol) == cfgHsOutPol);
      expVs = vsH[1] ^ cfgVsInvert;
      expClamp = cfgClampSrc ? isActive(exH[1], cfgClampPol)
                             : inPulse(haveEdge, lastEdge, cyc, int'(cfgPlace), int'(cfgDur));
      hsH = {hsH[2:0], hsyncIn};
      vsH = {vsH[2:0], vsyncIn};
      coH = {coH[2:0], coastIn};
      exH = {exH[2:0], clampExtIn};
    end
  end

  task automatic check(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic checkCount(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // per-cycle comparison of all outputs
  int hiCnt = 0;
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check("R8", "hsyncOut", hsyncOut, expHs);
      check("R9", "vsyncOut", vsyncOut, expVs);
      check(cfgClampSrc ? "R7" : phaseTag, "clampOut", clampOut, expClamp);
      if (clampOut) hiCnt++;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    hsyncIn = ~cfgHsInPol;
    coastIn = ~cfgCoastPol;
    clampExtIn = 1'b0;
    vsyncIn = 1'b0;
    repeat (3) @(negedge clk);
    // R10: outputs held low during reset
    check("R10", "hsyncOut in reset", hsyncOut, 1'b0);
    check("R10", "vsyncOut in reset", vsyncOut, 1'b0);
    check("R10", "clampOut in reset", clampOut, 1'b0);
    rstN = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic hsPulses(int num, int width, int gap);
    for (int p = 0; p < num; p++) begin
      for (int w = 0; w < width; w++) begin
        @(negedge clk);
        hsyncIn = cfgHsInPol;
        if ($urandom % 8 == 0) vsyncIn = ~vsyncIn;
      end
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        hsyncIn = ~cfgHsInPol;
        if ($urandom % 8 == 0) vsyncIn = ~vsyncIn;
      end
    end
  endtask

  task automatic randomRun(int n);
    bit hsOn = 0;
    int left = 5;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      if (left == 0) begin
        hsOn = !hsOn;
        left = hsOn ? int'($urandom % 4) + 1 : int'($urandom % 40) + 2;
      end
      left--;
      hsyncIn = hsOn ? cfgHsInPol : ~cfgHsInPol;
      if ($urandom % 60 == 0) coastIn = ~coastIn;
      if ($urandom % 10 == 0) vsyncIn = ~vsyncIn;
      clampExtIn = 1'($urandom % 2);
    end
  endtask

  int base;

  initial begin
    void'($urandom(32'h5EED_C1A5));

    // R10 and R1: reset-value configuration, rising leading edge
    phaseTag = "R1";
    doReset();
    base = hiCnt;
    hsPulses(3, 3, 30);
    repeat (20) @(negedge clk);
    checkCount("R1", "clamp cycles, rising edge lead", hiCnt - base, 3 * 6);

    // R2: falling leading edge, negative sync out, no frame inversion
    phaseTag = "R2";
    cfgHsInPol = 1'b0; cfgHsOutPol = 1'b0; cfgVsInvert = 1'b0;
    cfgPlace = 8'd2; cfgDur = 8'd3;
    doReset();
    base = hiCnt;
    hsPulses(4, 5, 25);
    repeat (20) @(negedge clk);
    checkCount("R2", "clamp cycles, falling edge lead", hiCnt - base, 4 * 3);

    // R4: zero duration
    phaseTag = "R4";
    cfgHsInPol = 1'b1; cfgPlace = 8'd3; cfgDur = 8'd0;
    doReset();
    base = hiCnt;
    hsPulses(4, 2, 20);
    repeat (20) @(negedge clk);
    checkCount("R4", "clamp cycles with zero duration", hiCnt - base, 0);

    // R5: edges every 8 pixels abandon pulses that would start 11 pixels after
    phaseTag = "R5";
    cfgPlace = 8'd8; cfgDur = 8'd10;
    doReset();
    base = hiCnt;
    hsPulses(5, 2, 6);
    repeat (40) @(negedge clk);
    checkCount("R5", "only the last pulse completes", hiCnt - base, 10);

    // R6: coast active low blocks three pulses, then two pass
    phaseTag = "R6";
    cfgCoastPol = 1'b0; cfgPlace = 8'd2; cfgDur = 8'd5;
    doReset();
    base = hiCnt;
    @(negedge clk); coastIn = 1'b0;
    hsPulses(3, 3, 27);
    @(negedge clk); coastIn = 1'b1;
    hsPulses(2, 3, 27);
    repeat (20) @(negedge clk);
    checkCount("R6", "clamp cycles with coast gating", hiCnt - base, 2 * 5);

    // R7: external clamp, both polarities
    for (int pol = 0; pol < 2; pol++) begin
      cfgClampSrc = 1'b1; cfgClampPol = 1'(pol); cfgCoastPol = 1'b1;
      doReset();
      randomRun(300);
    end

    // R3: random rounds across every setting
    phaseTag = "R3";
    for (int r = 0; r < 8; r++) begin
      cfgHsInPol  = 1'($urandom % 2);
      cfgCoastPol = 1'($urandom % 2);
      cfgClampSrc = ($urandom % 4 == 0);
      cfgClampPol = 1'($urandom % 2);
      cfgHsOutPol = 1'($urandom % 2);
      cfgVsInvert = 1'($urandom % 2);
      cfgPlace    = 8'($urandom % 20);
      cfgDur      = 8'($urandom % 12);
      doReset();
      randomRun(2500);
    end

    // R3 boundary: largest placement and duration
    cfgClampSrc = 1'b0; cfgHsInPol = 1'b1; cfgCoastPol = 1'b1;
    cfgPlace = 8'd255; cfgDur = 8'd255;
    doReset();
    base = hiCnt;
    hsPulses(1, 3, 560);
    checkCount("R3", "clamp cycles at maximum settings", hiCnt - base, 255);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule